// File: doc/BRIEF.md
# Seven-segment gate sequencer for a four-state three-level inverter leg set

This block turns one sampling period of a space-vector modulator into switch gate signals for a three-phase inverter whose legs each have four switches and four legal states. Once per period an upstream stage hands over three dwell times, in clock cycles: one for the small vector, one for the medium vector and one for the large vector. It also hands over four three-phase state codes: two redundant forms of the small vector, the medium vector and the large vector. The block splits the dwells across a symmetric seven-segment pattern, times each segment with a counter and applies the matching state to every phase.

Each phase state is decoded into four gate lines. A per-phase guard watches the step from the state now on the gates to the requested one. If a step would hand conduction directly from one inner switch to the other, that phase is switched fully off for one cycle and its fault line is raised. Segments of zero length are never shown on the outputs. The input set is taken only at a period boundary. A period with no new set repeats the last one. A set with all dwells zero parks the block in its idle state.

Phase state encoding (two bits, phase A in bits 1:0, B in 3:2, C in 5:4 of each code): 00 = 1+, 01 = 0+, 10 = 0−, 11 = 1−. Gate bus: bit 4p+k drives switch S(k+1) of phase p (p = 0 for A, 1 for B, 2 for C).

Top module: `svm7_sequencer`

## Requirements
- R1: After synchronous reset every phase is held in state 0− (gate bus 0xAAA), the segment index is 0, the period strobe and all fault lines are low, and in_ready is high.
- R2: The gate nibble of a phase, bits S4..S1, is 0011 for 1+, 0101 for 0+, 1010 for 0− and 1100 for 1−.
- R3: S2 and S3 of one phase are never high in the same cycle.
- R4: A step in which one inner switch would turn off and the other turn on (1+↔0+, 0−↔1−, 1+↔1−, 0+↔0−) is blocked: that phase drives 0000 and raises its fault line for one cycle, then applies the requested state. Other steps, and steps out of the off state, take effect at once with fault low.
- R5: Segments 0..6 apply the codes small-first, medium, large, small-second, large, medium, small-first, and seg_idx shows the segment now applied.
- R6: Segment lengths in cycles are: segments 0 and 6 get Ts>>2; segment 3 gets Ts−2·(Ts>>2); segment 1 gets Tm>>1 and segment 5 gets Tm−(Tm>>1); segment 2 gets Tl>>1 and segment 4 gets Tl−(Tl>>1). A period lasts Ts+Tm+Tl cycles.
- R7: A segment of zero length is skipped and never appears on seg_idx or the gates.
- R8: in_ready is high in the last cycle of a period and whenever idle. A set offered with in_valid in such a cycle is taken at that edge, and its first non-empty segment is applied in the next cycle, with period_start high for exactly that cycle.
- R9: When no set is offered at a boundary, the latched set is repeated unchanged.
- R10: A taken set whose three dwells are all zero returns the block to idle: all phases requested 0−, seg_idx 0, in_ready high.
- R11: in_valid with any data in a cycle where in_ready is low has no effect on the current or any later period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream offers a new period set |
| in_ready | output | 1 | Block takes a set at this edge |
| dwell_small | input | TW | Small-vector dwell, cycles |
| dwell_mid | input | TW | Medium-vector dwell, cycles |
| dwell_large | input | TW | Large-vector dwell, cycles |
| code_sp | input | 6 | Small vector, first form |
| code_mid | input | 6 | Medium vector |
| code_lg | input | 6 | Large vector |
| code_sn | input | 6 | Small vector, second form |
| gate | output | 12 | Gate lines, four per phase |
| seg_idx | output | 3 | Segment now applied |
| period_start | output | 1 | First cycle of a period |
| fault | output | 3 | Per-phase blocked-step flag |

## Verification
A wrong segment counter or skip decision appears on seg_idx and in_ready in the very cycle it goes wrong. Because the pattern is symmetric, an off-by-one in a split also moves period_start by a cycle one period later. A wrong latched code or a stale interlock memory shows up on the gate nibbles in the first cycle of the affected segment. A missing block shows up as a fault line staying low on a swap step. Every cycle of every period is compared against an arithmetic model of the split and of the four-state interlock, so no divergence lasts more than one cycle unobserved.

// File: rtl/svm7_pkg.sv
// Shared types and helpers for the seven-segment gate sequencer.
// Assumes the two-bit phase-state encoding 00=1+, 01=0+, 10=0-, 11=1-.
package svm7_pkg;

    localparam int NPH  = 3;   // phases
    localparam int NSEG = 7;   // segments per period
    localparam int NCOD = 4;   // distinct codes per period

    typedef enum logic [1:0] {
        PS_HI = 2'b00,   // 1+
        PS_ZH = 2'b01,   // 0+
        PS_ZL = 2'b10,   // 0-
        PS_LO = 2'b11    // 1-
    } pstate_t;

    // Gate nibble {S4,S3,S2,S1} for one phase state.
    function automatic logic [3:0] gate_of(pstate_t s);
        case (s)
            PS_HI:   gate_of = 4'b0011;
            PS_ZH:   gate_of = 4'b0101;
            PS_ZL:   gate_of = 4'b1010;
            default: gate_of = 4'b1100;
        endcase
    endfunction

    // True when a step hands conduction from one inner switch to the other.
    function automatic logic swap_hazard(logic [3:0] from_g, logic [3:0] to_g);
        swap_hazard = (from_g[1] & to_g[2] & ~to_g[1]) |
                      (from_g[2] & to_g[1] & ~to_g[2]);
    endfunction

    // Code slot used by each segment: A B C D C B A.
    function automatic logic [1:0] code_slot(logic [2:0] seg);
        case (seg)
            3'd0, 3'd6: code_slot = 2'd0;
            3'd1, 3'd5: code_slot = 2'd1;
            3'd2, 3'd4: code_slot = 2'd2;
            default:    code_slot = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/svm7_seg_timer.sv
// Segment timer: holds the seven segment lengths of the current period,
// counts each down, skips empty segments and opens the input handshake
// only at a period boundary or while idle.
// Assumes dwell inputs are stable while in_valid is high.
module svm7_seg_timer
    import svm7_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [TW-1:0] dw_s_i,
    input  logic [TW-1:0] dw_m_i,
    input  logic [TW-1:0] dw_l_i,
    output logic          ready_o,
    output logic          accept_o,
    output logic          run_o,
    output logic [2:0]    seg_o,
    output logic          start_o
);

    localparam logic [2:0] NONE = 3'(NSEG);

    logic [NSEG-1:0][TW-1:0] len_q, len_new, len_src;
    logic [TW-1:0]           cnt_q;
    logic [2:0]              seg_q, nxt, first;
    logic                    running_q, start_q, boundary;

    // First segment at or after 'from' with a non-zero length, NONE if none.
    function automatic logic [2:0] first_nz(logic [NSEG-1:0][TW-1:0] l, int from);
        first_nz = NONE;
        for (int i = NSEG - 1; i >= 0; i--)
            if (i >= from && l[i] != '0) first_nz = 3'(i);
    endfunction

    // Split the offered dwells over the symmetric pattern.
    always_comb begin
        len_new[0] = dw_s_i >> 2;
        len_new[6] = dw_s_i >> 2;
        len_new[3] = dw_s_i - (dw_s_i >> 2) - (dw_s_i >> 2);
        len_new[1] = dw_m_i >> 1;
        len_new[5] = dw_m_i - (dw_m_i >> 1);
        len_new[2] = dw_l_i >> 1;
        len_new[4] = dw_l_i - (dw_l_i >> 1);
    end

    // Boundary detection and choice of the next period's source set.
    always_comb begin
        nxt      = first_nz(len_q, int'(seg_q) + 1);
        boundary = !running_q || (cnt_q == TW'(1) && nxt == NONE);
        accept_o = valid_i && boundary;
        len_src  = accept_o ? len_new : len_q;
        first    = first_nz(len_src, 0);
    end

    // Segment and counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q     <= '0;
            cnt_q     <= '0;
            seg_q     <= '0;
            running_q <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (accept_o) len_q <= len_new;
            if (boundary) begin
                if (first != NONE) begin
                    running_q <= 1'b1;
                    seg_q     <= first;
                    cnt_q     <= len_src[first];
                    start_q   <= 1'b1;
                end else begin
                    running_q <= 1'b0;
                    seg_q     <= '0;
                    cnt_q     <= '0;
                end
            end else if (cnt_q == TW'(1)) begin
                seg_q <= nxt;
                cnt_q <= len_q[nxt];
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign ready_o = boundary;
    assign run_o   = running_q;
    assign seg_o   = seg_q;
    assign start_o = start_q;

    // R7: an applied segment always has cycles left.
    p_live_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> cnt_q != '0);
    // R5: within a period the segment index never goes back.
    p_seg_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !start_q && $past(running_q)) |-> seg_q >= $past(seg_q));
    // R8: a period starts only after the handshake was open.
    p_start_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(ready_o));

endmodule

// File: rtl/svm7_phase_drive.sv
// One phase leg driver: decodes the requested state to four gates and
// blocks any step that would swap the inner switches, driving all-off for
// one cycle and flagging a fault. Assumes one request per clock.
module svm7_phase_drive
    import svm7_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pstate_t    req_i,
    output logic [3:0] gate_o,
    output logic       fault_o
);

    logic [3:0] prev_q, cand;

    // Decode the request and apply the inner-switch guard.
    always_comb begin
        cand    = gate_of(req_i);
        fault_o = swap_hazard(prev_q, cand);
        gate_o  = fault_o ? 4'b0000 : cand;
    end

    // Remember what is on the gates now.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= gate_of(PS_ZL);
        else        prev_q <= gate_o;
    end

    // R3: inner switches never both on.
    p_inner_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[1] && gate_o[2]));
    // R4: no direct handover between the inner switches across a cycle.
    p_no_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(gate_o[1]) && gate_o[2]) && !($past(gate_o[2]) && gate_o[1]));
    // R4: a fault cycle leaves the leg fully off.
    p_fault_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> gate_o == 4'b0000);

endmodule

// File: rtl/svm7_sequencer.sv
// Seven-segment gate sequencer: latches a period's codes at the handshake,
// selects the code for the running segment and drives three phase legs.
// Assumes dwells are in clock cycles and codes use the svm7_pkg encoding.
module svm7_sequencer
    import svm7_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [TW-1:0]   dwell_small,
    input  logic [TW-1:0]   dwell_mid,
    input  logic [TW-1:0]   dwell_large,
    input  logic [5:0]      code_sp,
    input  logic [5:0]      code_mid,
    input  logic [5:0]      code_lg,
    input  logic [5:0]      code_sn,
    output logic [4*NPH-1:0] gate,
    output logic [2:0]      seg_idx,
    output logic            period_start,
    output logic [NPH-1:0]  fault
);

    localparam int CW = 2 * NPH;

    logic [NCOD-1:0][CW-1:0] code_q;
    logic [CW-1:0]           slot_code;
    logic                    accept, running;

    svm7_seg_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (in_valid),
        .dw_s_i   (dwell_small),
        .dw_m_i   (dwell_mid),
        .dw_l_i   (dwell_large),
        .ready_o  (in_ready),
        .accept_o (accept),
        .run_o    (running),
        .seg_o    (seg_idx),
        .start_o  (period_start)
    );

    // Hold the four codes of the running period.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= {NCOD{{NPH{PS_ZL}}}};
        else if (accept) code_q <= {code_sn, code_lg, code_mid, code_sp};
    end

    // Pick the code for the current segment.
    always_comb slot_code = code_q[code_slot(seg_idx)];

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        pstate_t req;
        // Idle legs rest in 0-.
        always_comb req = running ? pstate_t'(slot_code[2*p +: 2]) : PS_ZL;

        svm7_phase_drive u_drv (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req),
            .gate_o  (gate[4*p +: 4]),
            .fault_o (fault[p])
        );
    end

    // R10: a second idle cycle always shows every leg in 0-.
    p_idle_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(!running)) |-> gate == {NPH{4'b1010}});

endmodule

// File: tb/test_svm7_sequencer.sv
module test_svm7_sequencer;

    localparam int CLK_NS = 10;
    localparam int TW     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [TW-1:0] dwell_small = '0, dwell_mid = '0, dwell_large = '0;
    logic [5:0]    code_sp = '0, code_mid = '0, code_lg = '0, code_sn = '0;
    logic [11:0]   gate;
    logic [2:0]    seg_idx;
    logic          period_start;
    logic [2:0]    fault;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    int  exp_prev [3];   // 0..3 phase state, 4 = off

    always #(CLK_NS/2) clk = ~clk;

    svm7_sequencer #(.TW(TW)) i_svm7_sequencer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .dwell_small(dwell_small), .dwell_mid(dwell_mid), .dwell_large(dwell_large),
        .code_sp(code_sp), .code_mid(code_mid), .code_lg(code_lg), .code_sn(code_sn),
        .gate(gate), .seg_idx(seg_idx), .period_start(period_start), .fault(fault)
    );

    function automatic logic [5:0] enc(int a, int b, int c);
        return {c[1:0], b[1:0], a[1:0]};
    endfunction

    // R2 table.
    function automatic int exp_gate(int s);
        case (s)
            0: return 4'b0011;
            1: return 4'b0101;
            2: return 4'b1010;
            3: return 4'b1100;
            default: return 0;
        endcase
    endfunction

    // R4 list of blocked steps.
    function automatic bit blocked(int a, int b);
        if (a == 4) return 0;
        return (a==0 && b==1) || (a==1 && b==0) || (a==2 && b==3) || (a==3 && b==2) ||
               (a==0 && b==3) || (a==3 && b==0) || (a==1 && b==2) || (a==2 && b==1);
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_cycle(input int seg, input bit ps, input bit rdy,
                               input int ra, input int rb, input int rc,
                               input string rtag);
        int req [3];
        int eg, ef;
        req[0] = ra; req[1] = rb; req[2] = rc;
        chk({"R5 R6 R7 seg_idx ", rtag}, int'(seg_idx), seg);
        chk({"R8 period_start ", rtag}, int'(period_start), int'(ps));
        chk({"R8 in_ready ", rtag}, int'(in_ready), int'(rdy));
        for (int p = 0; p < 3; p++) begin
            if (blocked(exp_prev[p], req[p])) begin
                eg = 0; ef = 1; exp_prev[p] = 4;
            end else begin
                eg = exp_gate(req[p]); ef = 0; exp_prev[p] = req[p];
            end
            chk({"R2 R4 gate nibble ", rtag}, int'(gate[4*p +: 4]), eg);
            chk({"R4 fault ", rtag}, int'(fault[p]), ef);
            chk("R3 inner pair", int'(gate[4*p+1] & gate[4*p+2]), 0);
        end
    endtask

    // Offer one set in a ready cycle, then follow nrep periods cycle by cycle.
    task automatic run_set(input int t0, input int t1, input int t2,
                           input logic [5:0] ca, input logic [5:0] cb,
                           input logic [5:0] cc, input logic [5:0] cd,
                           input int nrep, input bit noise);
        int L [7];
        int seq [800];
        int P;
        logic [5:0] cs [4];
        in_valid = 1'b1;
        dwell_small = t0[TW-1:0]; dwell_mid = t1[TW-1:0]; dwell_large = t2[TW-1:0];
        code_sp = ca; code_mid = cb; code_lg = cc; code_sn = cd;
        step();
        in_valid = 1'b0;
        cs[0] = ca; cs[1] = cb; cs[2] = cc; cs[3] = cd;
        // R6 split
        L[0] = t0 / 4; L[6] = t0 / 4; L[3] = t0 - 2 * (t0 / 4);
        L[1] = t1 / 2; L[5] = t1 - t1 / 2;
        L[2] = t2 / 2; L[4] = t2 - t2 / 2;
        P = 0;
        for (int s = 0; s < 7; s++)
            for (int k = 0; k < L[s]; k++) begin seq[P] = s; P++; end
        if (P == 0) begin
            for (int i = 0; i < 3; i++) begin
                check_cycle(0, 0, 1, 2, 2, 2, "R10 idle");
                if (i < 2) step();
            end
        end else begin
            for (int rep = 0; rep < nrep; rep++) begin
                for (int i = 0; i < P; i++) begin
                    int s, sl;
                    logic [5:0] c;
                    s  = seq[i];
                    sl = (s == 0 || s == 6) ? 0 : (s == 1 || s == 5) ? 1 :
                         (s == 2 || s == 4) ? 2 : 3;
                    c  = cs[sl];
                    check_cycle(s, i == 0, i == P - 1,
                                int'(c[1:0]), int'(c[3:2]), int'(c[5:4]),
                                rep > 0 ? (noise ? "R9 R11" : "R9") : "R5");
                    if (noise && rep == 0 && i < P - 1) begin
                        in_valid = 1'b1;
                        dwell_small = 8'h11; dwell_mid = 8'h05; dwell_large = 8'h03;
                        code_sp = 6'h3f; code_mid = 6'h15; code_lg = 6'h2a; code_sn = 6'h00;
                    end else begin
                        in_valid = 1'b0;
                    end
                    if (!(rep == nrep - 1 && i == P - 1)) step();
                end
            end
        end
    endtask

    initial begin
        int t0l [7] = '{0, 1, 2, 3, 4, 5, 9};
        int t1l [4] = '{0, 1, 3, 6};
        int t2l [4] = '{0, 1, 2, 7};
        logic [5:0] cset [3][4];
        int idx = 0;
        cset[0] = '{enc(0,1,1), enc(0,1,3), enc(0,3,3), enc(2,3,3)};
        cset[1] = '{enc(0,0,1), enc(0,0,3), enc(0,2,3), enc(2,2,3)};
        cset[2] = '{enc(1,1,1), enc(0,0,0), enc(3,3,3), enc(2,2,2)};
        repeat (3) step();
        // R1 reset state
        chk("R1 gate", int'(gate), 12'hAAA);
        chk("R1 seg_idx", int'(seg_idx), 0);
        chk("R1 period_start", int'(period_start), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 fault", int'(fault), 0);
        for (int p = 0; p < 3; p++) exp_prev[p] = 2;
        rst_n = 1'b1;
        foreach (t0l[a]) foreach (t1l[b]) foreach (t2l[c]) begin
            int k;
            k = idx % 3;
            run_set(t0l[a], t1l[b], t2l[c], cset[k][0], cset[k][1], cset[k][2],
                    cset[k][3], 2, (idx % 4) == 0);
            if (idx % 16 == 15) run_set(0, 0, 0, 6'h0, 6'h0, 6'h0, 6'h0, 1, 0);
            idx++;
        end
        run_set(255, 255, 255, cset[0][0], cset[0][1], cset[0][2], cset[0][3], 1, 0);
        run_set(0, 0, 0, 6'h0, 6'h0, 6'h0, 6'h0, 1, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule